// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the programming side of an eight-input interrupt controller. A host reaches it over a byte-wide register bus with one address bit and separate read and write strobes. Writes to address 0 are sorted by their data pattern into three kinds: the opening initialization word, end-of-interrupt and priority commands, and read-select or special-mask commands. Writes to address 1 go to a different place depending on the initialization sequence. While a sequence is open they fill in the remaining initialization words. When no sequence is open they load the interrupt mask.

The initialization handshake has a variable length. The opening word states whether a cascade word follows and whether a final mode word follows. The sequencer skips the words that were not announced and then returns to idle. The block holds the request register, the in-service register and the mask register. It raises its interrupt output only for requests that are not masked. The priority and end-of-interrupt commands leave the block as one-cycle strobes that carry a command code and a level. The end-of-interrupt codes also clear bits in the in-service register. In-service bits are set by a neighbouring acknowledge unit through a set vector.

Top module: `pic_cmd_seq`

## Requirements
- R1: After reset the sequencer is idle (`init_busy`=0), the mask is 0, level triggering is selected (`trig_edge`=0), an address-0 read returns the request register, and `int_out` is 0.
- R2: A write to address 0 with data bit 4 set is the opening word. It clears the mask and the request register. It sets `trig_edge` from bit 3, sets `cascade_en` to the inverse of bit 1 and sets `need_w4` from bit 0. It then raises `init_busy` to wait for the base word.
- R3: The next address-1 write is the base word: `vec_base` becomes the byte with its low 3 bits cleared. If `cascade_en` is 0, `casc_map` is forced to 0 and the sequencer goes idle. Otherwise it waits for the cascade word.
- R4: The cascade word loads `casc_map`. In the default master build all 8 bits are kept. A slave build keeps only bits 2:0. After this word the sequencer waits for the mode word if `need_w4` is 1, and goes idle otherwise.
- R5: The mode word sets `nested_en` from bit 4, `buf_mode` from bits 3:2, `auto_eoi` from bit 1 and `cpu_mode` from bit 0, then returns to idle.
- R6: An address-1 write while idle loads the mask. An address-1 read returns the mask. All read data appears on `bus_rdata` in the cycle after the read strobe.
- R7: An address-0 write with bit 4 = 0 and bit 3 = 1 is a select command. If bit 1 is 1, bit 0 selects the source of address-0 reads: 1 selects the request register and 0 selects the in-service register. If bit 1 is 0 the selection is unchanged. If bit 7 is 1, `smask_stb` pulses for one cycle with `smask_val` equal to bit 6.
- R8: An address-0 write with bits 4:3 = 00 pulses `ocw2_stb` for one cycle, with `ocw2_cmd` equal to bits 7:5 and `ocw2_lvl` equal to bits 2:0.
- R9: On the strobe, commands 3 and 7 clear the in-service bit named by the level. Commands 1 and 5 clear the lowest-numbered in-service bit that is set. Other codes leave the in-service register unchanged. `svc_set` sets in-service bits. If a set and a clear hit the same bit in the same cycle, the bit ends set.
- R10: In level mode each request bit follows its line with one register of delay. In edge mode a request bit is set on a rising edge of its line. It stays set after the line falls, until `svc_set` for that bit clears it.
- R11: `int_out` is high exactly when some request bit is set and its mask bit is 0. A masked request does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Register address bit |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| irq_in | input | 8 | Interrupt request lines |
| svc_set | input | 8 | In-service set vector from the acknowledge unit |
| int_out | output | 1 | Interrupt output |
| init_busy | output | 1 | An initialization sequence is open |
| trig_edge | output | 1 | Edge triggering selected |
| cascade_en | output | 1 | Cascade mode selected |
| need_w4 | output | 1 | Mode word announced |
| vec_base | output | 8 | Vector base |
| casc_map | output | 8 | Slave map or slave identity |
| nested_en | output | 1 | Special nested mode |
| buf_mode | output | 2 | Buffering mode field |
| auto_eoi | output | 1 | Automatic end of interrupt |
| cpu_mode | output | 1 | Processor mode bit |
| ocw2_stb | output | 1 | Priority/EOI command strobe |
| ocw2_cmd | output | 3 | Command code |
| ocw2_lvl | output | 3 | Command level |
| smask_stb | output | 1 | Special mask update strobe |
| smask_val | output | 1 | Special mask value |

## Verification
A specific end-of-interrupt command and a service-set for the same level can land in the same cycle. The bench provokes this by driving `svc_set` while the command strobe is high. It then expects the in-service bit, read back through the bus, to remain set. A second collision is checked in edge mode. A rising edge on one line is latched while `svc_set` retires another line. The bench judges both results at the request register read port and at `int_out`.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } seq_e;

  localparam logic [2:0] CMD_EOI_ANY     = 3'd1;
  localparam logic [2:0] CMD_EOI_LVL     = 3'd3;
  localparam logic [2:0] CMD_ROT_EOI_ANY = 3'd5;
  localparam logic [2:0] CMD_ROT_EOI_LVL = 3'd7;
endpackage

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
  import pic_pkg::*;
#(
  parameter int  N_IRQ     = 8,
  parameter bit  IS_MASTER = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_wr,
  input  logic             cfg_wr,
  input  logic [N_IRQ-1:0] wdata,
  output logic             busy,
  output logic             trig_edge,
  output logic             cascade_en,
  output logic             need_w4,
  output logic [N_IRQ-1:0] vec_base,
  output logic [N_IRQ-1:0] casc_map,
  output logic             nested_en,
  output logic [1:0]       buf_mode,
  output logic             auto_eoi,
  output logic             cpu_mode
);
  localparam int LVL_W = $clog2(N_IRQ);

  seq_e state_q, state_d;
  logic             open_en, base_en, casc_en, mode_en;
  logic [N_IRQ-1:0] casc_d;

  always_comb begin
    state_d = state_q;
    if (open_wr) begin
      state_d = ST_BASE;
    end else if (cfg_wr) begin
      unique case (state_q)
        ST_BASE: state_d = cascade_en ? ST_CASC : ST_IDLE;
        ST_CASC: state_d = need_w4 ? ST_MODE : ST_IDLE;
        ST_MODE: state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign open_en = open_wr;
  assign base_en = cfg_wr && !open_wr && (state_q == ST_BASE);
  assign casc_en = (base_en && !cascade_en) ||
                   (cfg_wr && !open_wr && (state_q == ST_CASC));
  assign mode_en = cfg_wr && !open_wr && (state_q == ST_MODE);

  generate
    if (IS_MASTER) begin : g_master
      always_comb casc_d = (state_q == ST_CASC) ? wdata : '0;
    end else begin : g_slave
      always_comb begin
        casc_d = '0;
        if (state_q == ST_CASC) casc_d[LVL_W-1:0] = wdata[LVL_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_edge  <= 1'b0;
      cascade_en <= 1'b0;
      need_w4    <= 1'b0;
    end else if (open_en) begin
      trig_edge  <= wdata[3];
      cascade_en <= !wdata[1];
      need_w4    <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vec_base <= '0;
    else if (base_en) vec_base <= {wdata[N_IRQ-1:LVL_W], {LVL_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       casc_map <= '0;
    else if (casc_en) casc_map <= casc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nested_en <= 1'b0;
      buf_mode  <= 2'b00;
      auto_eoi  <= 1'b0;
      cpu_mode  <= 1'b0;
    end else if (mode_en) begin
      nested_en <= wdata[4];
      buf_mode  <= wdata[3:2];
      auto_eoi  <= wdata[1];
      cpu_mode  <= wdata[0];
    end
  end

  assign busy = (state_q != ST_IDLE);

  a_r3_single_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BASE && cfg_wr && !open_wr && !cascade_en)
      |=> (state_q == ST_IDLE && casc_map == '0));
  a_r4_mode_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CASC && cfg_wr && !open_wr && !need_w4) |=> (state_q == ST_IDLE));
  a_r5_mode_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MODE && cfg_wr && !open_wr) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/pic_req_track.sv
module pic_req_track #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_edge,
  input  logic             clr_all,
  input  logic [N_IRQ-1:0] lines,
  input  logic [N_IRQ-1:0] svc_set,
  output logic [N_IRQ-1:0] irr
);
  logic [N_IRQ-1:0] lines_q, irr_d, rise;
  logic             up_q;

  assign rise = lines & ~lines_q;

  always_comb begin
    if (clr_all)        irr_d = '0;
    else if (trig_edge) irr_d = (irr | rise) & ~svc_set;
    else                irr_d = lines;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= '0;
      irr     <= '0;
      up_q    <= 1'b0;
    end else begin
      lines_q <= lines;
      irr     <= irr_d;
      up_q    <= 1'b1;
    end
  end

  a_r10_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !trig_edge && !$past(trig_edge) && !$past(clr_all)) |-> (irr == $past(lines)));
  a_r10_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_edge && !clr_all) |=> ((irr & ~$past(svc_set)) == ($past(irr) & ~$past(svc_set)) ||
                                 ((irr & ~$past(irr)) != '0)));
endmodule

// File: rtl/pic_isr_ctrl.sv
module pic_isr_ctrl
  import pic_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_stb,
  input  logic [2:0]       cmd_code,
  input  logic [$clog2(N_IRQ)-1:0] cmd_lvl,
  input  logic [N_IRQ-1:0] svc_set,
  output logic [N_IRQ-1:0] isr
);
  logic [N_IRQ-1:0] low_one, clr_vec, isr_d;

  always_comb begin
    low_one = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (isr[i]) begin
        low_one    = '0;
        low_one[i] = 1'b1;
      end
    end
  end

  always_comb begin
    clr_vec = '0;
    if (cmd_stb) begin
      unique case (cmd_code)
        CMD_EOI_LVL, CMD_ROT_EOI_LVL: clr_vec[cmd_lvl] = 1'b1;
        CMD_EOI_ANY, CMD_ROT_EOI_ANY: clr_vec = low_one;
        default:                      clr_vec = '0;
      endcase
    end
  end

  assign isr_d = (isr & ~clr_vec) | svc_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= '0;
    else        isr <= isr_d;
  end

  a_r9_specific_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && (cmd_code == CMD_EOI_LVL) && !svc_set[cmd_lvl]) |=> !isr[$past(cmd_lvl)]);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_set != '0) |=> ((isr & $past(svc_set)) == $past(svc_set)));
endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq
  import pic_pkg::*;
#(
  parameter int N_IRQ     = 8,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [N_IRQ-1:0] bus_wdata,
  output logic [N_IRQ-1:0] bus_rdata,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic [N_IRQ-1:0] svc_set,
  output logic             int_out,
  output logic             init_busy,
  output logic             trig_edge,
  output logic             cascade_en,
  output logic             need_w4,
  output logic [N_IRQ-1:0] vec_base,
  output logic [N_IRQ-1:0] casc_map,
  output logic             nested_en,
  output logic [1:0]       buf_mode,
  output logic             auto_eoi,
  output logic             cpu_mode,
  output logic             ocw2_stb,
  output logic [2:0]       ocw2_cmd,
  output logic [$clog2(N_IRQ)-1:0] ocw2_lvl,
  output logic             smask_stb,
  output logic             smask_val
);
  localparam int LVL_W = $clog2(N_IRQ);

  logic             wr_open, wr_cmd, wr_sel, wr_cfg, wr_mask;
  logic [N_IRQ-1:0] imr, imr_d, irr, isr, rd_mux;
  logic             rd_irr_q, rd_irr_d;

  assign wr_open = bus_wr && !bus_addr && bus_wdata[4];
  assign wr_cmd  = bus_wr && !bus_addr && (bus_wdata[4:3] == 2'b00);
  assign wr_sel  = bus_wr && !bus_addr && (bus_wdata[4:3] == 2'b01);
  assign wr_cfg  = bus_wr && bus_addr && init_busy;
  assign wr_mask = bus_wr && bus_addr && !init_busy;

  pic_init_fsm #(.N_IRQ(N_IRQ), .IS_MASTER(IS_MASTER)) u_fsm (
    .clk(clk), .rst_n(rst_n), .open_wr(wr_open), .cfg_wr(wr_cfg), .wdata(bus_wdata),
    .busy(init_busy), .trig_edge(trig_edge), .cascade_en(cascade_en), .need_w4(need_w4),
    .vec_base(vec_base), .casc_map(casc_map), .nested_en(nested_en), .buf_mode(buf_mode),
    .auto_eoi(auto_eoi), .cpu_mode(cpu_mode)
  );

  pic_req_track #(.N_IRQ(N_IRQ)) u_req (
    .clk(clk), .rst_n(rst_n), .trig_edge(trig_edge), .clr_all(wr_open),
    .lines(irq_in), .svc_set(svc_set), .irr(irr)
  );

  pic_isr_ctrl #(.N_IRQ(N_IRQ)) u_isr (
    .clk(clk), .rst_n(rst_n), .cmd_stb(ocw2_stb), .cmd_code(ocw2_cmd),
    .cmd_lvl(ocw2_lvl), .svc_set(svc_set), .isr(isr)
  );

  always_comb begin
    imr_d = imr;
    if (wr_open)      imr_d = '0;
    else if (wr_mask) imr_d = bus_wdata;
  end

  always_comb begin
    rd_irr_d = rd_irr_q;
    if (wr_sel && bus_wdata[1]) rd_irr_d = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr      <= '0;
      rd_irr_q <= 1'b1;
    end else begin
      imr      <= imr_d;
      rd_irr_q <= rd_irr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocw2_stb  <= 1'b0;
      smask_stb <= 1'b0;
    end else begin
      ocw2_stb  <= wr_cmd;
      smask_stb <= wr_sel && bus_wdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocw2_cmd <= '0;
      ocw2_lvl <= '0;
    end else if (wr_cmd) begin
      ocw2_cmd <= bus_wdata[7:5];
      ocw2_lvl <= bus_wdata[LVL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        smask_val <= 1'b0;
    else if (wr_sel && bus_wdata[7])   smask_val <= bus_wdata[6];
  end

  assign rd_mux = bus_addr ? imr : (rd_irr_q ? irr : isr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign int_out = |(irr & ~imr);

  a_r2_open_clears_mask: assert property (@(posedge clk) disable iff (!rst_n)
    wr_open |=> (imr == '0 && init_busy));
  a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr && !init_busy) |=> (imr == $past(bus_wdata)));
  a_r8_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && bus_wdata[4:3] == 2'b00)
      |=> (ocw2_stb && ocw2_cmd == $past(bus_wdata[7:5])));
  a_r11_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == '1) |-> !int_out);
endmodule

// File: tb/pic_cmd_seq_test.sv
`timescale 1ns/1ps
module pic_cmd_seq_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_addr, bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata, irq_in, svc_set;
  logic       int_out, init_busy, trig_edge, cascade_en, need_w4;
  logic [7:0] vec_base, casc_map;
  logic       nested_en, auto_eoi, cpu_mode, ocw2_stb, smask_stb, smask_val;
  logic [1:0] buf_mode;
  logic [2:0] ocw2_cmd, ocw2_lvl;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string      q_tag[$];
  logic [7:0] q_exp[$];
  logic       rd_pend = 1'b0;

  always #2.5 clk = ~clk;

  pic_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .svc_set(svc_set),
    .int_out(int_out), .init_busy(init_busy), .trig_edge(trig_edge), .cascade_en(cascade_en),
    .need_w4(need_w4), .vec_base(vec_base), .casc_map(casc_map), .nested_en(nested_en),
    .buf_mode(buf_mode), .auto_eoi(auto_eoi), .cpu_mode(cpu_mode), .ocw2_stb(ocw2_stb),
    .ocw2_cmd(ocw2_cmd), .ocw2_lvl(ocw2_lvl), .smask_stb(smask_stb), .smask_val(smask_val)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic a, logic [7:0] exp, string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    q_tag.push_back(tag); q_exp.push_back(exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  always @(posedge clk) rd_pend <= bus_rd;

  always @(negedge clk) begin
    if (rd_pend && q_exp.size() > 0) begin
      chk(q_tag.pop_front(), bus_rdata, q_exp.pop_front());
    end
  end

  task automatic cfg_chk(string tag, logic [7:0] eb, logic [7:0] ec, logic [7:0] ew,
                         logic [7:0] vb, logic [7:0] cm, logic [7:0] m4);
    chk({tag, " busy"}, {7'd0, init_busy}, eb);
    chk({tag, " cascade"}, {7'd0, cascade_en}, ec);
    chk({tag, " need_w4"}, {7'd0, need_w4}, ew);
    chk({tag, " vec_base"}, vec_base, vb);
    chk({tag, " casc_map"}, casc_map, cm);
    chk({tag, " mode fields"}, {3'd0, nested_en, buf_mode, auto_eoi, cpu_mode}, m4);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; irq_in = '0; svc_set = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 busy", {7'd0, init_busy}, 8'h00);
    chk("R1 trig_edge", {7'd0, trig_edge}, 8'h00);
    chk("R1 int_out", {7'd0, int_out}, 8'h00);
    rd(1'b1, 8'h00, "R1 mask after reset");
    irq_in = 8'h03; tick();
    rd(1'b0, 8'h03, "R1 read select is request reg");
    irq_in = 8'h00; tick();

    // Full path: cascade, mode word announced
    wr(1'b1, 8'h5A);
    rd(1'b1, 8'h5A, "R6 mask load");
    wr(1'b0, 8'h19);
    chk("R2 trig_edge", {7'd0, trig_edge}, 8'h01);
    cfg_chk("R2 opening", 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    rd(1'b1, 8'h00, "R2 mask cleared");
    wr(1'b1, 8'h47);
    cfg_chk("R3 base cascade", 8'h01, 8'h01, 8'h01, 8'h40, 8'h00, 8'h00);
    wr(1'b1, 8'hA5);
    cfg_chk("R4 cascade word", 8'h01, 8'h01, 8'h01, 8'h40, 8'hA5, 8'h00);
    wr(1'b1, 8'h1F);
    cfg_chk("R5 mode word", 8'h00, 8'h01, 8'h01, 8'h40, 8'hA5, 8'h1F);

    // Single mode, no mode word
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h3C);
    cfg_chk("R3 single path", 8'h00, 8'h00, 8'h00, 8'h38, 8'h00, 8'h1F);

    // Cascade, no mode word
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h08);
    wr(1'b1, 8'h04);
    cfg_chk("R4 no mode word", 8'h00, 8'h01, 8'h00, 8'h08, 8'h04, 8'h1F);
    wr(1'b1, 8'h0F);
    rd(1'b1, 8'h0F, "R6 idle write is mask");
    chk("R6 casc_map kept", casc_map, 8'h04);

    // Level mode requests against mask
    irq_in = 8'h01; tick(); tick();
    chk("R11 masked request quiet", {7'd0, int_out}, 8'h00);
    irq_in = 8'h10; tick(); tick();
    chk("R11 unmasked request", {7'd0, int_out}, 8'h01);
    irq_in = 8'h00; tick(); tick();
    chk("R10 level follows line", {7'd0, int_out}, 8'h00);
    irq_in = 8'h30; tick();
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h30, "R10 level request reg");

    // Edge mode, single, no mode word
    wr(1'b0, 8'h1A);
    wr(1'b1, 8'h20);
    tick();
    chk("R10 no edge while held high", {7'd0, int_out}, 8'h00);
    irq_in = 8'h00; tick();
    irq_in = 8'h04; tick(); tick();
    chk("R10 rising edge latched", {7'd0, int_out}, 8'h01);
    irq_in = 8'h00; tick(); tick();
    rd(1'b0, 8'h04, "R10 edge request held");
    // collision: new edge on line 1 while line 2 retired
    irq_in = 8'h02; svc_set = 8'h04; tick();
    svc_set = 8'h00; tick();
    rd(1'b0, 8'h02, "R10 edge and service same cycle");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h04, "R7 in-service selected");

    // EOI handling
    svc_set = 8'h84; tick(); svc_set = 8'h00;
    wr(1'b0, 8'h20);
    chk("R8 strobe high", {7'd0, ocw2_stb}, 8'h01);
    chk("R8 cmd code", {5'd0, ocw2_cmd}, 8'h01);
    chk("R8 level", {5'd0, ocw2_lvl}, 8'h00);
    tick();
    chk("R8 strobe one cycle", {7'd0, ocw2_stb}, 8'h00);
    rd(1'b0, 8'h80, "R9 nonspecific clears lowest");
    wr(1'b0, 8'h67);
    tick();
    rd(1'b0, 8'h00, "R9 specific clears level 7");
    svc_set = 8'h20; tick(); svc_set = 8'h00;
    wr(1'b0, 8'h45);
    chk("R8 noop level", {5'd0, ocw2_lvl}, 8'h05);
    tick();
    rd(1'b0, 8'h20, "R9 noop leaves in-service");
    wr(1'b0, 8'h65);
    svc_set = 8'h20; tick(); svc_set = 8'h00;
    rd(1'b0, 8'h20, "R9 set wins over clear");
    wr(1'b0, 8'h65);
    tick();
    rd(1'b0, 8'h00, "R9 specific clears level 5");

    // Select unchanged when bit 1 clear; special mask strobe
    wr(1'b0, 8'h09);
    rd(1'b0, 8'h00, "R7 select unchanged");
    wr(1'b0, 8'hC8);
    chk("R7 smask strobe", {6'd0, smask_stb, smask_val}, 8'h03);
    tick();
    chk("R7 smask one cycle", {7'd0, smask_stb}, 8'h00);
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h02, "R7 request reg reselected");

    repeat (3) tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule